// File: doc/BRIEF.md
# Asymmetric PWM Generator

This block turns a free-running up-counter into a single-output pulse-width modulator. Software sets a period and an active time through a small register interface, chooses the output polarity, and starts the counter. Each PWM cycle the counter climbs from zero to the period value and restarts. The output is asserted while the count is below the active time and deasserted for the rest of the cycle.

Period and active-time writes land in shadow registers. The running waveform only picks them up at the moment the counter wraps, so a change never produces a runt pulse or an overlong cycle. One control bit switches the unit between PWM behaviour and its capture personality. In capture personality this generator stays idle and its output is parked at the inactive level.

Top module: `asym_pwm_gen`

## Requirements
- R1: After reset the output is low, the counter is stopped, and the shadow period, shadow compare and control registers all read as zero.
- R2: A write at offset 0x10 sets the shadow period and one at 0x14 sets the shadow compare, each truncated to the counter width. At offset 0x28, bit 20 is run, bit 25 is PWM mode and bit 26 is polarity. Reads at these offsets return the stored values. All other control bits read as zero.
- R3: The counter advances only while both run and PWM mode are set. It counts 0, 1, ... up to the active period, then returns to 0, so one PWM cycle lasts period+1 clocks.
- R4: With polarity clear, the output is high while the count is below the active compare value and low from that count up to the period.
- R5: A compare value of zero gives a constantly inactive output. A compare value equal to or above the period gives a constantly active output.
- R6: With polarity set, the output is the inverse of the R4/R5 waveform.
- R7: Period and compare writes made while running leave the current cycle unchanged. The new values apply from the clock edge where the counter wraps to zero.
- R8: While the counter is stopped, the output holds the inactive level (low for polarity clear, high for polarity set). On the first clock after starting, the count is 0 and the most recent shadow values are in effect.
- R9: With PWM mode clear, the counter stays at zero and the output stays inactive, even when run is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write byte offset |
| wrData | input | 32 | Register write data |
| rdAddr | input | ADDR_W | Register read byte offset |
| rdData | output | 32 | Register read data (combinational) |
| pwmOut | output | 1 | PWM output |

## Verification
The bench builds the generator with an 8-bit counter and an 8-bit address. The narrow counter makes the largest period, 255, reachable in a few hundred clocks. That lets one test run a full cycle through the all-ones count and the wrap, and another confirm that wide writes are truncated. The address width is kept at 8 so the control offset 0x28 still decodes.

// File: rtl/asym_pwm_pkg.sv
package asym_pwm_pkg;
  localparam int BUS_W = 32;

  localparam int OFS_PERIOD  = 'h10;
  localparam int OFS_COMPARE = 'h14;
  localparam int OFS_CONTROL = 'h28;

  localparam int BIT_RUN    = 20;
  localparam int BIT_MODE   = 25;
  localparam int BIT_INVERT = 26;

  typedef struct packed {
    logic run;
    logic reload;
    logic invert;
  } pwmStrobes_t;
endpackage

// File: rtl/asym_pwm_ctrl.sv
module asym_pwm_ctrl
  import asym_pwm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BUS_W-1:0]  rdData,
  input  logic              atPeriod,
  output logic [CNT_W-1:0]  shadowPer,
  output logic [CNT_W-1:0]  shadowCmp,
  output pwmStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(OFS_PERIOD);
  localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(OFS_COMPARE);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CONTROL);

  logic runBit, modeBit, invBit;
  logic running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowPer <= '0;
      shadowCmp <= '0;
      runBit    <= 1'b0;
      modeBit   <= 1'b0;
      invBit    <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == A_PER) shadowPer <= wrData[CNT_W-1:0];
      if (wrAddr == A_CMP) shadowCmp <= wrData[CNT_W-1:0];
      if (wrAddr == A_CTL) begin
        runBit  <= wrData[BIT_RUN];
        modeBit <= wrData[BIT_MODE];
        invBit  <= wrData[BIT_INVERT];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == A_PER) rdData = BUS_W'(shadowPer);
    if (rdAddr == A_CMP) rdData = BUS_W'(shadowCmp);
    if (rdAddr == A_CTL) begin
      rdData[BIT_RUN]    = runBit;
      rdData[BIT_MODE]   = modeBit;
      rdData[BIT_INVERT] = invBit;
    end
  end

  assign running        = runBit & modeBit;
  assign strobes.run    = running;
  assign strobes.reload = !running || atPeriod;
  assign strobes.invert = invBit;

  // R2: a control write is reflected in the stored bits one cycle later
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_CTL) |=> (runBit == $past(wrData[BIT_RUN]) &&
                                   invBit == $past(wrData[BIT_INVERT])));
  // R9: without PWM mode the datapath is never told to run
  assert_mode_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !modeBit |-> !strobes.run);
endmodule

// File: rtl/asym_pwm_datapath.sv
module asym_pwm_datapath
  import asym_pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] shadowPer,
  input  logic [CNT_W-1:0] shadowCmp,
  input  pwmStrobes_t      strobes,
  output logic             atPeriod,
  output logic             pwmOut
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] activePer;
  logic [CNT_W-1:0] activeCmp;
  logic             activeLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      activePer <= '0;
      activeCmp <= '0;
    end else begin
      if (!strobes.run || atPeriod) cnt <= '0;
      else                          cnt <= cnt + 1'b1;
      if (strobes.reload) begin
        activePer <= shadowPer;
        activeCmp <= shadowCmp;
      end
    end
  end

  assign atPeriod  = (cnt == activePer);
  assign activeLvl = (activeCmp >= activePer) ? (activeCmp != '0 || activePer == '0) && (activeCmp != '0)
                                              : (cnt < activeCmp);
  assign pwmOut    = strobes.run ? (activeLvl ^ strobes.invert) : strobes.invert;

  // R3: the count never passes the active period
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= activePer);
  // R3: the counter restarts from zero after reaching the period
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && atPeriod) |=> cnt == '0);
  // R7: active settings hold steady inside a running cycle
  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && !atPeriod) |=> ($stable(activePer) && $stable(activeCmp)));
  // R5: compare at or past the period with a nonzero compare keeps the output active
  assert_full_duty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && activeCmp != '0 && activeCmp >= activePer) |-> (pwmOut != strobes.invert));
endmodule

// File: rtl/asym_pwm_gen.sv
module asym_pwm_gen
  import asym_pwm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              pwmOut
);
  pwmStrobes_t      strobes;
  logic             atPeriod;
  logic [CNT_W-1:0] shadowPer;
  logic [CNT_W-1:0] shadowCmp;

  asym_pwm_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .atPeriod  (atPeriod),
    .shadowPer (shadowPer),
    .shadowCmp (shadowCmp),
    .strobes   (strobes)
  );

  asym_pwm_datapath #(.CNT_W(CNT_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .shadowPer (shadowPer),
    .shadowCmp (shadowCmp),
    .strobes   (strobes),
    .atPeriod  (atPeriod),
    .pwmOut    (pwmOut)
  );

  // R8: a stopped counter parks the output at the inactive level
  assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.run |-> pwmOut == strobes.invert);
endmodule

// File: tb/test_asym_pwm_gen.sv
`timescale 1ns/1ps
module test_asym_pwm_gen;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 8;
  localparam logic [31:0] C_RUN = 32'h0010_0000;
  localparam logic [31:0] C_MOD = 32'h0200_0000;
  localparam logic [31:0] C_INV = 32'h0400_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [31:0] rdData;
  logic pwmOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  asym_pwm_gen #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_asym_pwm_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pwmOut(pwmOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic regWrite(int addr, logic [31:0] data);
    wrEn = 1'b1; wrAddr = ADDR_W'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(string req, int addr, logic [31:0] exp);
    rdAddr = ADDR_W'(addr);
    #1;
    check(req, rdData, exp);
  endtask

  function automatic logic expLevel(int per, int cmp, bit inv, int idx);
    logic act;
    if (cmp == 0) act = 1'b0;
    else if (cmp >= per) act = 1'b1;
    else act = (idx < cmp);
    return act ^ inv;
  endfunction

  task automatic checkCycles(string req, int per, int cmp, bit inv, int startIdx, int n);
    for (int k = 0; k < n; k++) begin
      check(req, 32'(pwmOut), 32'(expLevel(per, cmp, inv, (startIdx + k) % (per + 1))));
      @(negedge clk);
    end
  endtask

  task automatic startPwm(int per, int cmp, bit inv);
    regWrite('h28, C_MOD | (inv ? C_INV : 32'h0));
    regWrite('h10, 32'(per));
    regWrite('h14, 32'(cmp));
    regWrite('h28, C_MOD | C_RUN | (inv ? C_INV : 32'h0));
  endtask

  task automatic testReset();
    check("R1 out", 32'(pwmOut), 32'h0);
    regRead("R1 ctrl", 'h28, 32'h0);
    regRead("R1 per", 'h10, 32'h0);
    regRead("R1 cmp", 'h14, 32'h0);
    checkCycles("R1 idle", 0, 0, 1'b0, 0, 3);
  endtask

  task automatic testRegs();
    regWrite('h10, 32'h0000_1234);
    regWrite('h14, 32'h0000_0007);
    regWrite('h28, C_MOD | C_INV | 32'h0000_00FF);
    regRead("R2 per trunc", 'h10, 32'h34);
    regRead("R2 cmp", 'h14, 32'h07);
    regRead("R2 ctrl bits", 'h28, C_MOD | C_INV);
    check("R8 idle inverted", 32'(pwmOut), 32'h1);
    regWrite('h28, 32'h0);
    check("R8 idle normal", 32'(pwmOut), 32'h0);
  endtask

  task automatic testBasic();
    startPwm(9, 3, 1'b0);
    checkCycles("R3 R4 basic", 9, 3, 1'b0, 0, 25);
  endtask

  task automatic testPolarity();
    startPwm(6, 2, 1'b1);
    checkCycles("R6 inverted", 6, 2, 1'b1, 0, 16);
  endtask

  task automatic testEdges();
    startPwm(5, 0, 1'b0);
    checkCycles("R5 zero cmp", 5, 0, 1'b0, 0, 12);
    startPwm(5, 5, 1'b0);
    checkCycles("R5 cmp eq per", 5, 5, 1'b0, 0, 12);
    startPwm(4, 9, 1'b1);
    checkCycles("R5 cmp gt per inv", 4, 9, 1'b1, 0, 12);
    startPwm(0, 0, 1'b0);
    checkCycles("R5 per0 cmp0", 0, 0, 1'b0, 0, 6);
    startPwm(0, 1, 1'b0);
    checkCycles("R5 per0 cmp1", 0, 1, 1'b0, 0, 6);
  endtask

  task automatic testShadow();
    startPwm(9, 3, 1'b0);
    checkCycles("R7 before", 9, 3, 1'b0, 0, 4);
    regWrite('h10, 32'd4);
    regWrite('h14, 32'd2);
    checkCycles("R7 old cycle kept", 9, 3, 1'b0, 6, 4);
    checkCycles("R7 new values", 4, 2, 1'b0, 0, 15);
  endtask

  task automatic testStop();
    startPwm(7, 3, 1'b1);
    checkCycles("R8 run", 7, 3, 1'b1, 0, 5);
    regWrite('h28, C_MOD | C_INV);
    for (int k = 0; k < 5; k++) begin
      check("R8 stopped inverted", 32'(pwmOut), 32'h1);
      @(negedge clk);
    end
    regWrite('h10, 32'd3);
    regWrite('h14, 32'd1);
    regWrite('h28, C_MOD | C_INV | C_RUN);
    checkCycles("R8 restart fresh", 3, 1, 1'b1, 0, 10);
  endtask

  task automatic testMode();
    regWrite('h28, 32'h0);
    regWrite('h10, 32'd5);
    regWrite('h14, 32'd3);
    regWrite('h28, C_RUN);
    for (int k = 0; k < 8; k++) begin
      check("R9 capture mode idle", 32'(pwmOut), 32'h0);
      @(negedge clk);
    end
    regWrite('h28, C_RUN | C_MOD);
    checkCycles("R9 mode on starts at zero", 5, 3, 1'b0, 0, 12);
  endtask

  task automatic testLong();
    startPwm(255, 128, 1'b0);
    checkCycles("R3 full width wrap", 255, 128, 1'b0, 0, 300);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testBasic();
    testPolarity();
    testEdges();
    testShadow();
    testStop();
    testMode();
    testLong();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule